// File: doc/BRIEF.md
# Nibble-Accessed Reloadable Timer Bank

This peripheral sits beside a 4-bit processor core. It contains four down-counters:
- an 8-bit prescaler;
- two 8-bit timers;
- a 4-bit timer.

Each counter has reload storage. The core reaches every 8-bit value one operation at a time through a pair of 4-bit data ports, one for the upper nibble and one for the lower. Each operation arrives as one bit of a one-hot strobe vector. A write updates a counter and the matching reload register in the same clock. The first timer also has a second reload register that can be written on its own. The second timer has a low and a high reload register. It switches between them on successive underflows, and an operation can copy its low reload value straight into the counter.

When a timer underflows, its request flag is set. The core polls these flags with test operations. When the matching mask bit is 0, a test clears a set flag and the block asks the core to skip its next instruction. When the mask bit is 1, the test does nothing. Instruction decode, interrupt vectoring and selection of the clock source belong to other blocks. Each counter instead receives a per-cycle count enable.

Top module: `nbt_bank`

## Requirements
- R1: After reset, every counter, reload register, request flag, the read data outputs and `skip` are 0.
- R2: `op` is one-hot or zero. The bit assignments are:
  - 0: prescaler read
  - 1: prescaler write
  - 2: timer one read
  - 3: timer one write
  - 4: timer one spare-reload write
  - 5: timer two read
  - 6: timer two low write
  - 7: timer two high write
  - 8: timer two load-from-low
  - 9: short timer write
  - 10, 11, 12: tests of flags 0, 1, 2

  A read operation shows the counter's upper nibble on `dout_hi` and its lower nibble on `dout_lo` from the next cycle. These outputs hold until the next read operation.
- R3: A prescaler write loads `{din_hi,din_lo}` into both the prescaler and its reload register. On an enabled cycle (`cnt_en[0]`) the prescaler decrements. At 0 it reloads instead. With no enable and no write it holds.
- R4: A timer one write loads `{din_hi,din_lo}` into the counter and its primary reload register. A spare-reload write loads only the spare reload register and leaves the counter unchanged.
- R5: When timer one underflows, it reloads from whichever of its two reload registers was written most recently.
- R6: A timer two low write loads the counter and the low reload register. A high write loads the counter and the high reload register.
- R7: Timer two reloads alternately from the low and high registers on successive underflows. A load-from-low operation copies the low register into the counter and makes the next underflow use the low register.
- R8: A short-timer write loads `din_lo` into the 4-bit counter and its reload register. Its underflow sets flag 2.
- R9: An enabled cycle on a counter that holds 0 is an underflow. It reloads the counter and sets the timer's flag in the same clock: timer one sets `irq_flag[0]` (`cnt_en[1]`), timer two sets `irq_flag[1]` (`cnt_en[2]`), and the short timer sets `irq_flag[2]` (`cnt_en[3]`).
- R10: A flag test with mask bit 0 on a set flag clears that flag and drives `skip` high for exactly the following cycle.
- R11: A flag test on a clear flag leaves `skip` low.
- R12: A flag test whose mask bit (`irq_mask[i]` for flag i) is 1 changes neither the flag nor `skip`.
- R13: If an underflow sets a flag in the same cycle that a test clears it, the flag ends up set.
- R14: A write to a counter takes priority over its count enable in the same cycle. The counter takes the written value, and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 13 | One-hot operation strobe |
| din_hi | input | 4 | Upper data nibble from core |
| din_lo | input | 4 | Lower data nibble from core |
| cnt_en | input | 4 | Count enables: prescaler, timer one, timer two, short timer |
| irq_mask | input | 3 | Per-flag mask; 1 turns a test into a no-op |
| dout_hi | output | 4 | Upper nibble of last read |
| dout_lo | output | 4 | Lower nibble of last read |
| irq_flag | output | 3 | Request flags |
| skip | output | 1 | Skip decision for the core |

## Verification
The assertions assume that `op` carries at most one strobe per cycle. The spare-reload and count-hold properties also assume that count enables may arrive together with any operation. The stimulus picks at most one operation index per cycle. It randomizes the data, enables and masks freely, and so produces write-versus-count and set-versus-clear collisions. A behavioural model in the bench tracks all four counters and the timer two phase, and compares the read data, flags and skip on every cycle.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    localparam int NIB       = 4;
    localparam int WIDE      = 2 * NIB;
    localparam int NUM_FLAGS = 3;
    localparam int NUM_CNT   = 4;

    localparam int OP_PRE_RD = 0;
    localparam int OP_PRE_WR = 1;
    localparam int OP_T1_RD  = 2;
    localparam int OP_T1_WR  = 3;
    localparam int OP_T1_SP  = 4;
    localparam int OP_T2_RD  = 5;
    localparam int OP_T2_WRL = 6;
    localparam int OP_T2_WRH = 7;
    localparam int OP_T2_LDL = 8;
    localparam int OP_SH_WR  = 9;
    localparam int OP_TST0   = 10;
    localparam int NUM_OPS   = OP_TST0 + NUM_FLAGS;

    typedef struct packed {
        logic [WIDE-1:0] pre_rel;
        logic [WIDE-1:0] t1_rel_pri;
        logic [WIDE-1:0] t1_rel_spr;
        logic            t1_use_spr;
        logic [WIDE-1:0] t2_rel_lo;
        logic [WIDE-1:0] t2_rel_hi;
        logic            t2_use_hi;
        logic [NIB-1:0]  sh_rel;
        logic [NIB-1:0]  rd_hi;
        logic [NIB-1:0]  rd_lo;
    } bank_t;
endpackage

// File: rtl/nbt_downcnt.sv
module nbt_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] rl_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = en && !ld && (cnt_q == '0);
        cnt_d = cnt_q;
        if (ld)
            cnt_d = ld_val;
        else if (wrap)
            cnt_d = rl_val;
        else if (en)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_wrap_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == $past(rl_val));
    p_load_wins_r14: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> $stable(cnt));
endmodule

// File: rtl/nbt_flags.sv
module nbt_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] tst,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flag,
    output logic         skip
);
    logic [N-1:0] flag_d, flag_q;
    logic [N-1:0] hit;
    logic         skip_d, skip_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        assign hit[i]    = tst[i] && !mask[i];
        assign flag_d[i] = set[i] || (flag_q[i] && !hit[i]);

        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (tst[i] && !mask[i] && flag[i] && !set[i]) |=> !flag[i]);
        p_masked_nop_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (tst[i] && mask[i] && !set[i]) |=> flag[i] == $past(flag[i]));
        p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
    end

    always_comb skip_d = |(hit & flag_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            skip_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            skip_q <= skip_d;
        end
    end

    assign flag = flag_q;
    assign skip = skip_q;

    p_skip_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tst & ~mask & flag)) |=> skip);
    p_no_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tst & ~flag) && !(|(tst & flag))) |=> !skip);
endmodule

// File: rtl/nbt_bank.sv
module nbt_bank
    import nbt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_OPS-1:0]   op,
    input  logic [NIB-1:0]       din_hi,
    input  logic [NIB-1:0]       din_lo,
    input  logic [NUM_CNT-1:0]   cnt_en,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    output logic [NIB-1:0]       dout_hi,
    output logic [NIB-1:0]       dout_lo,
    output logic [NUM_FLAGS-1:0] irq_flag,
    output logic                 skip
);
    bank_t st_d, st_q;

    logic [WIDE-1:0] din_w;
    logic [WIDE-1:0] pre_cnt, t1_cnt, t2_cnt;
    logic [NIB-1:0]  sh_cnt;
    logic            pre_wrap, t1_wrap, t2_wrap, sh_wrap;
    logic            t2_ld;
    logic [WIDE-1:0] t1_rl, t2_rl, t2_ldv;

    assign din_w  = {din_hi, din_lo};
    assign t1_rl  = st_q.t1_use_spr ? st_q.t1_rel_spr : st_q.t1_rel_pri;
    assign t2_rl  = st_q.t2_use_hi ? st_q.t2_rel_hi : st_q.t2_rel_lo;
    assign t2_ld  = op[OP_T2_WRL] || op[OP_T2_WRH] || op[OP_T2_LDL];
    assign t2_ldv = op[OP_T2_LDL] ? st_q.t2_rel_lo : din_w;

    nbt_downcnt #(.W(WIDE)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(cnt_en[0]), .ld(op[OP_PRE_WR]),
        .ld_val(din_w), .rl_val(st_q.pre_rel), .cnt(pre_cnt), .wrap(pre_wrap));

    nbt_downcnt #(.W(WIDE)) u_t1 (
        .clk(clk), .rst_n(rst_n), .en(cnt_en[1]), .ld(op[OP_T1_WR]),
        .ld_val(din_w), .rl_val(t1_rl), .cnt(t1_cnt), .wrap(t1_wrap));

    nbt_downcnt #(.W(WIDE)) u_t2 (
        .clk(clk), .rst_n(rst_n), .en(cnt_en[2]), .ld(t2_ld),
        .ld_val(t2_ldv), .rl_val(t2_rl), .cnt(t2_cnt), .wrap(t2_wrap));

    nbt_downcnt #(.W(NIB)) u_sh (
        .clk(clk), .rst_n(rst_n), .en(cnt_en[3]), .ld(op[OP_SH_WR]),
        .ld_val(din_lo), .rl_val(st_q.sh_rel), .cnt(sh_cnt), .wrap(sh_wrap));

    nbt_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set({sh_wrap, t2_wrap, t1_wrap}),
        .tst(op[OP_TST0 +: NUM_FLAGS]),
        .mask(irq_mask),
        .flag(irq_flag), .skip(skip));

    always_comb begin
        st_d = st_q;
        if (op[OP_PRE_WR])
            st_d.pre_rel = din_w;
        if (op[OP_T1_WR]) begin
            st_d.t1_rel_pri = din_w;
            st_d.t1_use_spr = 1'b0;
        end
        if (op[OP_T1_SP]) begin
            st_d.t1_rel_spr = din_w;
            st_d.t1_use_spr = 1'b1;
        end
        if (op[OP_T2_WRL])
            st_d.t2_rel_lo = din_w;
        if (op[OP_T2_WRH])
            st_d.t2_rel_hi = din_w;
        if (op[OP_T2_LDL])
            st_d.t2_use_hi = 1'b0;
        else if (t2_wrap)
            st_d.t2_use_hi = !st_q.t2_use_hi;
        if (op[OP_SH_WR])
            st_d.sh_rel = din_lo;
        if (op[OP_PRE_RD])
            {st_d.rd_hi, st_d.rd_lo} = pre_cnt;
        if (op[OP_T1_RD])
            {st_d.rd_hi, st_d.rd_lo} = t1_cnt;
        if (op[OP_T2_RD])
            {st_d.rd_hi, st_d.rd_lo} = t2_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout_hi = st_q.rd_hi;
    assign dout_lo = st_q.rd_lo;

    p_onehot_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op));
    p_spare_keeps_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op[OP_T1_SP] && !cnt_en[1]) |=> $stable(t1_cnt));
    p_t1_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_wrap && st_q.t1_use_spr) |=> t1_cnt == $past(st_q.t1_rel_spr));
    p_t2_lo_after_ldl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op[OP_T2_LDL] |=> (t2_cnt == $past(st_q.t2_rel_lo)) && !st_q.t2_use_hi);
    p_t2_alt_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_wrap && !st_q.t2_use_hi) |=> t2_cnt == $past(st_q.t2_rel_lo));
    p_pre_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wrap |=> pre_cnt == $past(st_q.pre_rel));
    p_short_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en[3] && !op[OP_SH_WR] && sh_cnt == '0) |=> irq_flag[2]);
endmodule

// File: tb/nbt_bank_test.sv
`timescale 1ns/1ps
module nbt_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] op = '0;
    logic [3:0]  din_hi = '0, din_lo = '0;
    logic [3:0]  cnt_en = '0;
    logic [2:0]  irq_mask = '0;
    logic [3:0]  dout_hi, dout_lo;
    logic [2:0]  irq_flag;
    logic        skip;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur = "R1";

    nbt_bank uut (
        .clk(clk), .rst_n(rst_n), .op(op), .din_hi(din_hi), .din_lo(din_lo),
        .cnt_en(cnt_en), .irq_mask(irq_mask), .dout_hi(dout_hi), .dout_lo(dout_lo),
        .irq_flag(irq_flag), .skip(skip));

    always #4 clk = ~clk;

    // behavioural reference model
    logic [7:0] m_pre, m_pre_r, m_t1, m_t1_a, m_t1_b, m_t2, m_t2_lo, m_t2_hi, m_rd;
    logic [3:0] m_sh, m_sh_r;
    logic       m_t1_b_last, m_t2_hi_next, m_skip;
    logic [2:0] m_fl, m_set;
    logic [7:0] v;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_pre_r = 0; m_t1 = 0; m_t1_a = 0; m_t1_b = 0;
            m_t2 = 0; m_t2_lo = 0; m_t2_hi = 0; m_rd = 0; m_sh = 0; m_sh_r = 0;
            m_t1_b_last = 0; m_t2_hi_next = 0; m_skip = 0; m_fl = 0;
        end else begin
            v = {din_hi, din_lo};
            m_set[0] = cnt_en[1] && !op[3] && m_t1 == 0;
            m_set[1] = cnt_en[2] && !(op[6] || op[7] || op[8]) && m_t2 == 0;
            m_set[2] = cnt_en[3] && !op[9] && m_sh == 0;
            if (op[0]) m_rd = m_pre;
            if (op[2]) m_rd = m_t1;
            if (op[5]) m_rd = m_t2;
            m_skip = 0;
            for (int i = 0; i < 3; i++) begin
                if (op[10+i] && !irq_mask[i] && m_fl[i]) m_skip = 1;
                if (m_set[i]) m_fl[i] = 1;
                else if (op[10+i] && !irq_mask[i]) m_fl[i] = 0;
            end
            if (op[1]) begin m_pre = v; m_pre_r = v; end
            else if (cnt_en[0]) m_pre = (m_pre == 0) ? m_pre_r : m_pre - 1;
            if (op[3]) begin m_t1 = v; m_t1_a = v; end
            else if (cnt_en[1]) m_t1 = (m_t1 == 0) ? (m_t1_b_last ? m_t1_b : m_t1_a) : m_t1 - 1;
            if (op[3]) m_t1_b_last = 0;
            if (op[4]) begin m_t1_b = v; m_t1_b_last = 1; end
            if (op[6]) begin m_t2 = v; m_t2_lo = v; end
            else if (op[7]) begin m_t2 = v; m_t2_hi = v; end
            else if (op[8]) begin m_t2 = m_t2_lo; m_t2_hi_next = 0; end
            else if (cnt_en[2]) begin
                if (m_t2 == 0) begin
                    m_t2 = m_t2_hi_next ? m_t2_hi : m_t2_lo;
                    m_t2_hi_next = !m_t2_hi_next;
                end else m_t2 = m_t2 - 1;
            end
            if (op[9]) begin m_sh = din_lo; m_sh_r = din_lo; end
            else if (cnt_en[3]) m_sh = (m_sh == 0) ? m_sh_r : m_sh - 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int idx, input logic [7:0] d, input logic [3:0] en,
                        input logic [2:0] msk);
        op = '0;
        if (idx >= 0 && idx < 13) op[idx] = 1'b1;
        {din_hi, din_lo} = d;
        cnt_en = en;
        irq_mask = msk;
        @(posedge clk);
        @(negedge clk);
        chk({cur, " model"}, {dout_hi, dout_lo, 1'b0, irq_flag, 3'b0, skip},
            {m_rd, 1'b0, m_fl, 3'b0, m_skip});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur = "R1";
        chk("R1 reset", {dout_hi, dout_lo, 1'b0, irq_flag, skip}, 0);
        tick(-1, 0, 0, 0);
        // R2 / R3 prescaler write and read
        cur = "R2";
        tick(1, 8'hA5, 0, 0);
        tick(0, 0, 0, 0);
        chk("R2 pre read", {dout_hi, dout_lo}, 8'hA5);
        cur = "R3";
        tick(-1, 0, 4'b0001, 0);
        tick(-1, 0, 4'b0001, 0);
        tick(-1, 0, 4'b0001, 0);
        tick(-1, 0, 0, 0);
        tick(0, 0, 0, 0);
        chk("R3 pre count", {dout_hi, dout_lo}, 8'hA2);
        tick(1, 8'h01, 0, 0);
        tick(-1, 0, 4'b0001, 0);
        tick(-1, 0, 4'b0001, 0);
        tick(0, 0, 0, 0);
        chk("R3 pre reload", {dout_hi, dout_lo}, 8'h01);
        // R4 spare write leaves counter
        cur = "R4";
        tick(3, 8'h3C, 0, 0);
        tick(4, 8'h77, 0, 0);
        tick(2, 0, 0, 0);
        chk("R4 t1 untouched", {dout_hi, dout_lo}, 8'h3C);
        // R5 most recent reload register
        cur = "R5";
        tick(3, 8'h00, 0, 0);
        tick(4, 8'h05, 0, 0);
        tick(-1, 0, 4'b0010, 0);
        chk("R9 t1 flag", irq_flag[0], 1);
        tick(2, 0, 0, 0);
        chk("R5 spare reload", {dout_hi, dout_lo}, 8'h05);
        tick(3, 8'h00, 0, 0);
        tick(-1, 0, 4'b0010, 0);
        tick(2, 0, 0, 0);
        chk("R5 primary reload", {dout_hi, dout_lo}, 8'h00);
        // R6 timer two writes
        cur = "R6";
        tick(6, 8'h12, 0, 0);
        tick(5, 0, 0, 0);
        chk("R6 low write", {dout_hi, dout_lo}, 8'h12);
        tick(7, 8'h34, 0, 0);
        tick(5, 0, 0, 0);
        chk("R6 high write", {dout_hi, dout_lo}, 8'h34);
        // R7 alternation
        cur = "R7";
        tick(6, 8'h00, 0, 0);
        tick(7, 8'h03, 0, 0);
        tick(8, 0, 0, 0);
        tick(5, 0, 0, 0);
        chk("R7 load low", {dout_hi, dout_lo}, 8'h00);
        tick(-1, 0, 4'b0100, 0);
        chk("R9 t2 flag", irq_flag[1], 1);
        tick(-1, 0, 4'b0100, 0);
        tick(5, 0, 0, 0);
        chk("R7 high second", {dout_hi, dout_lo}, 8'h03);
        // R8 short timer
        cur = "R8";
        tick(9, 8'h02, 0, 0);
        tick(-1, 0, 4'b1000, 0);
        tick(-1, 0, 4'b1000, 0);
        chk("R8 no flag yet", irq_flag[2], 0);
        tick(-1, 0, 4'b1000, 0);
        chk("R8 flag on underflow", irq_flag[2], 1);
        // R10 test clears and skips
        cur = "R10";
        tick(10, 0, 0, 3'b000);
        chk("R10 skip", skip, 1);
        chk("R10 cleared", irq_flag[0], 0);
        tick(-1, 0, 0, 0);
        chk("R10 one cycle", skip, 0);
        // R11 test on clear flag
        cur = "R11";
        tick(10, 0, 0, 3'b000);
        chk("R11 no skip", skip, 0);
        // R12 masked test
        cur = "R12";
        tick(11, 0, 0, 3'b010);
        chk("R12 no skip", skip, 0);
        chk("R12 flag kept", irq_flag[1], 1);
        // R13 set wins
        cur = "R13";
        tick(9, 8'h00, 0, 0);
        tick(12, 0, 4'b1000, 3'b000);
        chk("R13 skip", skip, 1);
        chk("R13 flag stays", irq_flag[2], 1);
        // R14 write beats count
        cur = "R14";
        tick(3, 8'h09, 4'b0010, 0);
        tick(2, 0, 0, 0);
        chk("R14 write wins", {dout_hi, dout_lo}, 8'h09);
        // R9 random traffic compared against the model every cycle
        cur = "R9";
        for (int n = 0; n < 4000; n++)
            tick($urandom_range(0, 15), 8'($urandom), 4'($urandom), 3'($urandom));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule